// File: doc/BRIEF.md
# Hashed Page Table Group Address Generator

This unit turns a translation request into the two memory addresses where the matching page table entry may live, plus the tag that a later stage compares against each entry. The inputs are a virtual segment identifier, the effective address, the page table base/size register and a set of shift and mask constants that describe the hash geometry. The hash mixes the segment identifier with the page index taken from the effective address. The primary group address places that hash inside the table. The secondary group address uses the complement of the hash inside the same hash mask.

Two table formats are supported and picked per request by a mode input. In wide mode the table size is a 5-bit exponent in the low bits of the base register, and exponents above the limit are rejected. In narrow mode the low 9 bits of the base register are used directly as the table mask. Each mode builds the compare tag in its own way. Wide-mode table groups hold eight 16-byte entries and narrow-mode groups hold eight 8-byte entries. The caller sets this through the constants it supplies. Reading and checking entries in memory is left to the next stage.

A request is presented with a one-cycle strobe. The results appear registered on the following cycle.

Top module: `hpt_addr_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid and size_err are 0 and group_addr0, group_addr1 and cmp_tag are all zero.
- R2: The page index is (eaddr & page_mask) >> 12. The primary hash is ((vsid ^ page index) << hash_shift) & hash_mask. group_addr0 holds the base bits OR'ed with (primary hash & combined mask).
- R3: group_addr1 uses the secondary hash (~primary hash) & hash_mask in the same way, so group_addr0 ^ group_addr1 has no bit set outside hash_mask.
- R4: In wide mode (mode = 1) the table mask is 0x0FFF_FFFF >> (28 - sdr1[4:0]). A size field of exactly 28 is legal. The combined mask is (table mask << base_shift) | base_mask.
- R5: In narrow mode (mode = 0) the table mask is sdr1[8:0], and the combined mask is built as in R4.
- R6: The base bits are sdr1 with every bit below bit base_shift cleared.
- R7: In wide mode cmp_tag = (vsid << 12) | ((page index >> 4) & 0xF80), so only five page-index bits reach the tag.
- R8: In narrow mode cmp_tag = (vsid << 7) | ((page index >> 10) & 0x3F).
- R9: In wide mode a size field sdr1[4:0] greater than 28 sets size_err for one cycle, keeps out_valid low and leaves all three result outputs unchanged. In narrow mode sdr1[4:0] never raises size_err.
- R10: Results and out_valid appear on the clock edge that follows the edge sampling in_valid = 1. A cycle without a strobe gives out_valid = 0 and size_err = 0, and the result outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 1 | 1 = wide table format, 0 = narrow table format |
| vsid | input | 64 | Virtual segment identifier |
| eaddr | input | 64 | Effective address |
| sdr1 | input | 64 | Table base and size register |
| page_mask | input | 64 | Mask selecting page-number bits of eaddr |
| hash_shift | input | 6 | Left shift applied to the raw hash |
| hash_mask | input | 64 | Mask applied to the shifted hash |
| base_shift | input | 6 | Position of the table base field in sdr1 |
| base_mask | input | 64 | Fixed mask OR'ed into the combined mask |
| out_valid | output | 1 | Results valid, one cycle after strobe |
| size_err | output | 1 | Illegal wide-mode table size seen |
| group_addr0 | output | 64 | Primary entry-group address |
| group_addr1 | output | 64 | Secondary entry-group address |
| cmp_tag | output | 64 | Entry compare tag |

## Verification
Every result of this block, the two group addresses, the tag, out_valid and size_err, is due on the single rising edge after the strobe. There is one register stage between the inputs and every output. The bench drives a request on a falling edge and drops the strobe on the next falling edge. It reads all outputs at that second falling edge, half a period after they were captured, and at that point it also checks the cycles without a strobe and the rejected requests for outputs that stayed unchanged.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    localparam int HPT_AW   = 64;
    localparam int HPT_SHW  = $clog2(HPT_AW);

    typedef enum logic {
        HPT_NARROW = 1'b0,
        HPT_WIDE   = 1'b1
    } hpt_mode_e;

    typedef struct packed {
        logic [HPT_AW-1:0] grp0;
        logic [HPT_AW-1:0] grp1;
        logic [HPT_AW-1:0] tag;
    } hpt_result_t;

    // All ones at and above bit position sh
    function automatic logic [HPT_AW-1:0] ones_from(input logic [HPT_SHW-1:0] sh);
        return {HPT_AW{1'b1}} << sh;
    endfunction

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
    import hpt_pkg::*;
#(
    parameter int AW        = HPT_AW,
    parameter int SHW       = HPT_SHW,
    parameter int PAGE_BITS = 12
) (
    input  logic [AW-1:0]  vsid,
    input  logic [AW-1:0]  eaddr,
    input  logic [AW-1:0]  page_mask,
    input  logic [SHW-1:0] hash_shift,
    input  logic [AW-1:0]  hash_mask,
    output logic [AW-1:0]  pgidx,
    output logic [AW-1:0]  hash_pri,
    output logic [AW-1:0]  hash_sec
);
    always_comb begin
        pgidx    = (eaddr & page_mask) >> PAGE_BITS;
        hash_pri = ((vsid ^ pgidx) << hash_shift) & hash_mask;
        hash_sec = (~hash_pri) & hash_mask;
    end
endmodule

// File: rtl/hpt_span.sv
module hpt_span
    import hpt_pkg::*;
#(
    parameter int AW         = HPT_AW,
    parameter int SHW        = HPT_SHW,
    parameter int SIZE_LIMIT = 28,
    parameter int NARROW_W   = 9
) (
    input  hpt_mode_e      mode,
    input  logic [AW-1:0]  sdr1,
    input  logic [SHW-1:0] base_shift,
    input  logic [AW-1:0]  base_mask,
    output logic [AW-1:0]  comb_mask,
    output logic [AW-1:0]  base_bits,
    output logic           size_bad
);
    localparam int SZ_W = $clog2(SIZE_LIMIT + 1);
    localparam logic [AW-1:0] SPAN_ONES = (AW'(1) << SIZE_LIMIT) - AW'(1);

    logic [SZ_W-1:0] size_fld;
    logic [SZ_W-1:0] span_shamt;
    logic [AW-1:0]   tbl_mask;

    always_comb begin
        size_fld   = sdr1[SZ_W-1:0];
        span_shamt = SZ_W'(SIZE_LIMIT) - size_fld;
        size_bad   = (mode == HPT_WIDE) && (size_fld > SZ_W'(SIZE_LIMIT));
        if (mode == HPT_WIDE)
            tbl_mask = SPAN_ONES >> span_shamt;
        else
            tbl_mask = AW'(sdr1[NARROW_W-1:0]);
        comb_mask = (tbl_mask << base_shift) | base_mask;
        base_bits = sdr1 & ones_from(base_shift);
    end
endmodule

// File: rtl/hpt_tag.sv
module hpt_tag
    import hpt_pkg::*;
#(
    parameter int AW           = HPT_AW,
    parameter int WIDE_VSH     = 12,
    parameter int WIDE_PSH     = 4,
    parameter int WIDE_PBITS   = 5,
    parameter int WIDE_PPOS   = 7,
    parameter int NARROW_VSH   = 7,
    parameter int NARROW_PSH   = 10,
    parameter int NARROW_PBITS = 6
) (
    input  hpt_mode_e     mode,
    input  logic [AW-1:0] vsid,
    input  logic [AW-1:0] pgidx,
    output logic [AW-1:0] tag
);
    localparam logic [AW-1:0] WIDE_FIELD   = ((AW'(1) << WIDE_PBITS) - AW'(1)) << WIDE_PPOS;
    localparam logic [AW-1:0] NARROW_FIELD = (AW'(1) << NARROW_PBITS) - AW'(1);

    always_comb begin
        if (mode == HPT_WIDE)
            tag = (vsid << WIDE_VSH) | ((pgidx >> WIDE_PSH) & WIDE_FIELD);
        else
            tag = (vsid << NARROW_VSH) | ((pgidx >> NARROW_PSH) & NARROW_FIELD);
    end
endmodule

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen
    import hpt_pkg::*;
#(
    parameter int AW         = HPT_AW,
    parameter int SHW        = HPT_SHW,
    parameter int PAGE_BITS  = 12,
    parameter int SIZE_LIMIT = 28
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic           mode,
    input  logic [AW-1:0]  vsid,
    input  logic [AW-1:0]  eaddr,
    input  logic [AW-1:0]  sdr1,
    input  logic [AW-1:0]  page_mask,
    input  logic [SHW-1:0] hash_shift,
    input  logic [AW-1:0]  hash_mask,
    input  logic [SHW-1:0] base_shift,
    input  logic [AW-1:0]  base_mask,
    output logic           out_valid,
    output logic           size_err,
    output logic [AW-1:0]  group_addr0,
    output logic [AW-1:0]  group_addr1,
    output logic [AW-1:0]  cmp_tag
);
    hpt_mode_e   mode_e;
    logic [AW-1:0] pgidx, h_pri, h_sec, cmask, base;
    logic          bad;
    hpt_result_t   res_d, res_q;

    assign mode_e = hpt_mode_e'(mode);

    hpt_hash #(.AW(AW), .SHW(SHW), .PAGE_BITS(PAGE_BITS)) u_hash (
        .vsid(vsid), .eaddr(eaddr), .page_mask(page_mask),
        .hash_shift(hash_shift), .hash_mask(hash_mask),
        .pgidx(pgidx), .hash_pri(h_pri), .hash_sec(h_sec)
    );

    hpt_span #(.AW(AW), .SHW(SHW), .SIZE_LIMIT(SIZE_LIMIT)) u_span (
        .mode(mode_e), .sdr1(sdr1), .base_shift(base_shift),
        .base_mask(base_mask), .comb_mask(cmask), .base_bits(base),
        .size_bad(bad)
    );

    hpt_tag #(.AW(AW)) u_tag (
        .mode(mode_e), .vsid(vsid), .pgidx(pgidx), .tag(res_d.tag)
    );

    assign res_d.grp0 = base | (h_pri & cmask);
    assign res_d.grp1 = base | (h_sec & cmask);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            size_err  <= 1'b0;
            res_q     <= '0;
        end else begin
            out_valid <= in_valid & ~bad;
            size_err  <= in_valid & bad;
            if (in_valid && !bad)
                res_q <= res_d;
        end
    end

    assign group_addr0 = res_q.grp0;
    assign group_addr1 = res_q.grp1;
    assign cmp_tag     = res_q.tag;
endmodule

// File: rtl/hpt_addr_gen_chk.sv
module hpt_addr_gen_chk #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [AW-1:0] hash_mask,
    input logic          out_valid,
    input logic          size_err,
    input logic [AW-1:0] group_addr0,
    input logic [AW-1:0] group_addr1,
    input logic [AW-1:0] cmp_tag
);
    assert_valid_err_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && size_err));

    assert_valid_needs_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !size_err));

    assert_err_holds_R9: assert property (@(posedge clk) disable iff (rst)
        size_err |-> ($stable(group_addr0) && $stable(group_addr1) && $stable(cmp_tag)));

    assert_sec_in_mask_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (((group_addr0 ^ group_addr1) & ~$past(hash_mask)) == '0));
endmodule

bind hpt_addr_gen hpt_addr_gen_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .hash_mask(hash_mask),
    .out_valid(out_valid), .size_err(size_err), .group_addr0(group_addr0),
    .group_addr1(group_addr1), .cmp_tag(cmp_tag)
);

// File: tb/hpt_addr_gen_bench.sv
module hpt_addr_gen_bench;
    localparam int AW = 64;
    localparam int NV = 6;

    typedef struct packed {
        logic          wide;
        logic [AW-1:0] vsid;
        logic [AW-1:0] ea;
        logic [AW-1:0] sdr;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        {1'b1, 64'h0000_0012_3456_789A, 64'h0000_0000_1234_5000, 64'h0000_0000_0F00_0005},
        {1'b1, 64'h0003_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_F000, 64'h0000_0001_0000_001C},
        {1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0ABC_D000, 64'h0000_0000_0004_0000},
        {1'b0, 64'h0000_0000_00AB_CDEF, 64'h0000_0000_1234_5678, 64'h0000_0000_0FF0_01FF},
        {1'b0, 64'h0000_0000_0001_2345, 64'h0000_0000_F00F_F000, 64'h0000_0000_0020_0003},
        {1'b0, 64'h0000_0000_00FF_FFFF, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_001F}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          mode = 1'b0;
    logic [AW-1:0] vsid = '0, eaddr = '0, sdr1 = '0, page_mask = '0;
    logic [5:0]    hash_shift = '0, base_shift = '0;
    logic [AW-1:0] hash_mask = '0, base_mask = '0;
    logic          out_valid, size_err;
    logic [AW-1:0] group_addr0, group_addr1, cmp_tag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hpt_addr_gen u_hpt_addr_gen (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .vsid(vsid),
        .eaddr(eaddr), .sdr1(sdr1), .page_mask(page_mask), .hash_shift(hash_shift),
        .hash_mask(hash_mask), .base_shift(base_shift), .base_mask(base_mask),
        .out_valid(out_valid), .size_err(size_err), .group_addr0(group_addr0),
        .group_addr1(group_addr1), .cmp_tag(cmp_tag)
    );

    task automatic check(input string req, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic set_geometry(input logic wide);
        page_mask = 64'h0000_0000_0FFF_FFFF;
        if (wide) begin
            hash_shift = 6'd7;  hash_mask = 64'h0000_007F_FFFF_FF80;
            base_shift = 6'd18; base_mask = 64'h0000_0000_0003_FF80;
        end else begin
            hash_shift = 6'd6;  hash_mask = 64'h0000_0000_01FF_FFC0;
            base_shift = 6'd16; base_mask = 64'h0000_0000_0000_FFC0;
        end
    endtask

    // Model written from the requirements
    task automatic expect_model(input logic wide, input logic [AW-1:0] v,
                                input logic [AW-1:0] e, input logic [AW-1:0] s,
                                output logic [AW-1:0] a0, output logic [AW-1:0] a1,
                                output logic [AW-1:0] tg, output logic bad);
        logic [AW-1:0] pg, hp, hs, tm, cm, bs;
        pg = (e & page_mask) >> 12;
        hp = ((v ^ pg) << hash_shift) & hash_mask;
        hs = ~hp & hash_mask;
        bad = wide && (s[4:0] > 5'd28);
        if (wide) tm = 64'h0FFF_FFFF >> (28 - int'(s[4:0]));
        else      tm = {55'd0, s[8:0]};
        cm = (tm << base_shift) | base_mask;
        bs = s & ({AW{1'b1}} << base_shift);
        a0 = bs | (hp & cm);
        a1 = bs | (hs & cm);
        if (wide) tg = (v << 12) | ((pg >> 4) & 64'hF80);
        else      tg = (v << 7)  | ((pg >> 10) & 64'h3F);
    endtask

    // Drive one strobe on a falling edge; sample at the next falling edge
    task automatic issue(input logic wide, input logic [AW-1:0] v,
                         input logic [AW-1:0] e, input logic [AW-1:0] s);
        @(negedge clk);
        set_geometry(wide);
        mode = wide; vsid = v; eaddr = e; sdr1 = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [AW-1:0] a0, a1, tg, p0, p1, pt;
        logic bad;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "out_valid", {63'd0, out_valid}, '0);
        check("R1", "size_err", {63'd0, size_err}, '0);
        check("R1", "group_addr0", group_addr0, '0);
        check("R1", "cmp_tag", cmp_tag, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "out_valid after release", {63'd0, out_valid}, '0);
        check("R1", "group_addr1 after release", group_addr1, '0);

        // Table walk: R2 R3 R6 with mode-specific R4/R5 and R7/R8
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].wide, VECS[i].vsid, VECS[i].ea, VECS[i].sdr);
            expect_model(VECS[i].wide, VECS[i].vsid, VECS[i].ea, VECS[i].sdr, a0, a1, tg, bad);
            check("R10", "out_valid", {63'd0, out_valid}, 64'd1);
            check("R9", "size_err", {63'd0, size_err}, '0);
            check(VECS[i].wide ? "R2 R4 R6" : "R2 R5 R6", "group_addr0", group_addr0, a0);
            check("R3", "group_addr1", group_addr1, a1);
            check(VECS[i].wide ? "R7" : "R8", "cmp_tag", cmp_tag, tg);
        end

        // R10: a cycle with no strobe, inputs changed
        p0 = group_addr0; p1 = group_addr1; pt = cmp_tag;
        vsid = 64'h5555; eaddr = 64'hAAAA_0000; sdr1 = 64'h1234_0007;
        @(negedge clk);
        check("R10", "idle out_valid", {63'd0, out_valid}, '0);
        check("R10", "idle size_err", {63'd0, size_err}, '0);
        check("R10", "idle group_addr0 held", group_addr0, p0);
        check("R10", "idle cmp_tag held", cmp_tag, pt);

        // R9: illegal wide size fields 29 and 31
        for (int k = 0; k < 2; k++) begin
            p0 = group_addr0; p1 = group_addr1; pt = cmp_tag;
            issue(1'b1, 64'h77, 64'h3000, k == 0 ? 64'h0100_001D : 64'h0100_001F);
            check("R9", "size_err", {63'd0, size_err}, 64'd1);
            check("R9", "out_valid", {63'd0, out_valid}, '0);
            check("R9", "group_addr0 held", group_addr0, p0);
            check("R9", "group_addr1 held", group_addr1, p1);
            check("R9", "cmp_tag held", cmp_tag, pt);
            @(negedge clk);
            check("R9", "size_err one cycle", {63'd0, size_err}, '0);
        end

        // R4: legal after an error, size 28 boundary on a new address
        issue(1'b1, 64'h0000_00AB_0000_0001, 64'h0FFF_F000, 64'h0000_0000_0000_001C);
        expect_model(1'b1, 64'h0000_00AB_0000_0001, 64'h0FFF_F000, 64'h1C, a0, a1, tg, bad);
        check("R4", "boundary out_valid", {63'd0, out_valid}, 64'd1);
        check("R4", "boundary group_addr0", group_addr0, a0);
        check("R3", "boundary group_addr1", group_addr1, a1);

        // R9: narrow mode ignores sdr1[4:0] as a size
        issue(1'b0, 64'h3C, 64'h0000_F000, 64'h0000_0000_0000_00FF);
        expect_model(1'b0, 64'h3C, 64'h0000_F000, 64'hFF, a0, a1, tg, bad);
        check("R9", "narrow no size_err", {63'd0, size_err}, '0);
        check("R5", "narrow group_addr0", group_addr0, a0);
        check("R8", "narrow cmp_tag", cmp_tag, tg);

        // R1: reset mid-run clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1", "re-reset group_addr0", group_addr0, '0);
        check("R1", "re-reset cmp_tag", cmp_tag, '0);
        rst = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule